// File: doc/BRIEF.md
# Clock-Loss Mute and Recovery Sequencer

This block supervises the master clock of an audio amplifier datapath using a free-running reference clock that is independent of it. When the master clock stops toggling, or when a sample-rate change is requested, the block forces the complementary PWM outputs into a fixed hard-mute polarity. It also holds the internal processing in reset, suspends the control bus and forces the volume gain to zero.

Once the master clock is present again, the block releases the processing reset and runs a timed partial re-initialization while the outputs stay muted. It then restarts the PWM outputs at zero gain and ramps the gain in equal steps back to the programmed target. All delays are counted in reference-clock cycles and set by parameters. The target gain comes from the control registers and is only read, never altered, so a setting made before an interruption is restored after it.

The sequencer has five states:
- RUN: normal operation.
- MUTE_HOLD: safe state.
- REINIT: partial re-initialization.
- PWM_RESTART: outputs live at zero gain.
- RAMP: gain rising to the target.

It moves between them as follows:
- RUN to MUTE_HOLD on clock loss or a rate change.
- MUTE_HOLD to REINIT once the clock is seen.
- REINIT to PWM_RESTART when its timer expires.
- PWM_RESTART to RAMP when its timer expires.
- RAMP to RUN when the last step is reached.
- Any state other than RUN back to MUTE_HOLD on clock loss or a rate change.

Top module: `clkloss_seq`

## Requirements
- R1: In RUN, the PWM and valid outputs equal their inputs and `gain` equals `target_gain`. In RUN, `proc_rst`, `bus_hold` and `ramp_active` are all low.
- R2: Clock loss is declared after LOSS_CYC consecutive reference cycles without a master-clock edge, with edges taken through a two-flop synchronizer. A shorter pause has no effect on the outputs.
- R3: Hard mute applies in MUTE_HOLD and REINIT. During hard mute every `pwm_p_out` bit is 0, every `pwm_m_out` bit is 1, every `valid_out` bit is 0, and `gain` is 0.
- R4: In MUTE_HOLD, `proc_rst` and `bus_hold` are 1. The block stays in MUTE_HOLD while the clock is missing, which includes the time after reset until the first edge.
- R5: REINIT lasts exactly REINIT_CYC cycles with hard mute on and `proc_rst` low.
- R6: PWM_RESTART lasts exactly RESTART_CYC cycles. In it the outputs pass through, `gain` is 0 and `ramp_active` is 0.
- R7: RAMP lasts STEPS*STEP_CYC+1 cycles with `ramp_active` high. In cycle i of RAMP, `gain` = (`target_gain`*k)>>STEP_LOG2 with k = min(i/STEP_CYC, STEPS) and STEPS = 2**STEP_LOG2. After RAMP the block enters RUN.
- R8: Clock loss in REINIT, PWM_RESTART or RAMP returns the block to MUTE_HOLD.
- R9: A `rate_change` pulse in any state puts the block in MUTE_HOLD on the next cycle, and the full recovery sequence follows.
- R10: After each recovery, `gain` settles at the unchanged `target_gain`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset |
| mclk | input | 1 | Supervised master clock (asynchronous) |
| rate_change | input | 1 | One-cycle sample-rate change request |
| target_gain | input | GW | Programmed volume level |
| pwm_p_in | input | CH | Positive PWM legs from modulator |
| pwm_m_in | input | CH | Negative PWM legs from modulator |
| valid_in | input | CH | Channel valid flags from modulator |
| pwm_p_out | output | CH | Gated positive PWM legs |
| pwm_m_out | output | CH | Gated negative PWM legs |
| valid_out | output | CH | Gated valid flags |
| proc_rst | output | 1 | Reset for internal processing |
| bus_hold | output | 1 | Suspends control-bus operations |
| ramp_active | output | 1 | High while the gain ramps |
| gain | output | GW | Current volume gain |

## Verification
The hardest case to reach from the ports is a clock loss that arrives in the middle of the gain ramp. The bench reaches it by tracking `ramp_active` and stopping the master-clock generator a few cycles after the ramp starts. It then checks that the mute comes back and that a full sequence runs after the clock resumes. The ramp itself is swept over several target levels, including 0, 1 and full scale, and every ramp cycle is compared with the arithmetic step value. The loss threshold is probed from both sides: a pause short of the limit must change nothing, and a longer one must mute.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
    typedef enum logic [2:0] {
        ST_RUN         = 3'd0,
        ST_MUTE_HOLD   = 3'd1,
        ST_REINIT      = 3'd2,
        ST_PWM_RESTART = 3'd3,
        ST_RAMP        = 3'd4
    } seq_state_t;
endpackage

// File: rtl/clkseq_loss_det.sv
module clkseq_loss_det #(
    parameter int LOSS_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk,
    output logic lost
);
    localparam int CW = $clog2(LOSS_CYC + 1);

    logic          s1, s2, s3;
    logic          edge_seen;
    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= mclk;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign edge_seen = s2 ^ s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= CW'(LOSS_CYC);
        end else if (edge_seen) begin
            idle_cnt <= '0;
        end else if (!lost) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign lost = (idle_cnt == CW'(LOSS_CYC));

    // R2: an observed edge clears the loss flag on the following cycle
    a_r2_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> !lost);
    // R2: loss can only start after a cycle with no edge
    a_r2_rise_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> !$past(edge_seen));
endmodule

// File: rtl/clkseq_ramp.sv
module clkseq_ramp #(
    parameter int GW        = 8,
    parameter int STEP_LOG2 = 2,
    parameter int STEP_CYC  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [GW-1:0] target,
    output logic [GW-1:0] level,
    output logic          done
);
    localparam int STEPS = 1 << STEP_LOG2;
    localparam int KW    = STEP_LOG2 + 1;
    localparam int YW    = $clog2(STEP_CYC + 1);
    localparam int PW    = GW + KW;

    logic [KW-1:0] k;
    logic [YW-1:0] cyc;
    logic [PW-1:0] prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k   <= '0;
            cyc <= '0;
        end else if (!en) begin
            k   <= '0;
            cyc <= '0;
        end else if (!done) begin
            if (cyc == YW'(STEP_CYC - 1)) begin
                cyc <= '0;
                k   <= k + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    assign done  = (k == KW'(STEPS));
    assign prod  = PW'(target) * PW'(k);
    assign level = prod[STEP_LOG2 +: GW];

    // R7: the step index never exceeds the final step
    a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        k <= KW'(STEPS));
endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
    import clkseq_pkg::*;
#(
    parameter int REINIT_CYC  = 40,
    parameter int RESTART_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lost,
    input  logic       rate_change,
    input  logic       ramp_done,
    output seq_state_t state
);
    localparam int MAXC = (REINIT_CYC > RESTART_CYC) ? REINIT_CYC : RESTART_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    seq_state_t    state_nx;
    logic [TW-1:0] tmr;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:         if (lost) state_nx = ST_MUTE_HOLD;
            ST_MUTE_HOLD:   if (!lost) state_nx = ST_REINIT;
            ST_REINIT:      if (tmr == TW'(REINIT_CYC - 1)) state_nx = ST_PWM_RESTART;
            ST_PWM_RESTART: if (tmr == TW'(RESTART_CYC - 1)) state_nx = ST_RAMP;
            ST_RAMP:        if (ramp_done) state_nx = ST_RUN;
            default:        state_nx = ST_MUTE_HOLD;
        endcase
        if (lost || rate_change) state_nx = ST_MUTE_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_MUTE_HOLD;
            tmr   <= '0;
        end else begin
            state <= state_nx;
            tmr   <= (state_nx != state) ? '0 : tmr + 1'b1;
        end
    end

    // R9: a rate change request always lands in the safe state
    a_r9_rate_to_mute: assert property (@(posedge clk) disable iff (!rst_n)
        rate_change |=> state == ST_MUTE_HOLD);
    // R8: clock loss outside RUN returns to the safe state
    a_r8_loss_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && state != ST_RUN) |=> state == ST_MUTE_HOLD);
    // R5: the restart phase is entered only from re-initialization
    a_r5_restart_after_reinit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM_RESTART && $past(state) != ST_PWM_RESTART) |-> $past(state) == ST_REINIT);
endmodule

// File: rtl/clkseq_top.sv
module clkloss_seq
    import clkseq_pkg::*;
#(
    parameter int CH          = 2,
    parameter int GW          = 8,
    parameter int LOSS_CYC    = 16,
    parameter int REINIT_CYC  = 40,
    parameter int RESTART_CYC = 8,
    parameter int STEP_LOG2   = 2,
    parameter int STEP_CYC    = 5
) (
    input  logic          ref_clk,
    input  logic          ref_rst_n,
    input  logic          mclk,
    input  logic          rate_change,
    input  logic [GW-1:0] target_gain,
    input  logic [CH-1:0] pwm_p_in,
    input  logic [CH-1:0] pwm_m_in,
    input  logic [CH-1:0] valid_in,
    output logic [CH-1:0] pwm_p_out,
    output logic [CH-1:0] pwm_m_out,
    output logic [CH-1:0] valid_out,
    output logic          proc_rst,
    output logic          bus_hold,
    output logic          ramp_active,
    output logic [GW-1:0] gain
);
    logic          lost;
    logic          ramp_done;
    logic [GW-1:0] ramp_level;
    seq_state_t    state;

    clkseq_loss_det #(.LOSS_CYC(LOSS_CYC)) u_det (
        .clk(ref_clk), .rst_n(ref_rst_n), .mclk(mclk), .lost(lost)
    );

    clkseq_fsm #(.REINIT_CYC(REINIT_CYC), .RESTART_CYC(RESTART_CYC)) u_fsm (
        .clk(ref_clk), .rst_n(ref_rst_n), .lost(lost),
        .rate_change(rate_change), .ramp_done(ramp_done), .state(state)
    );

    clkseq_ramp #(.GW(GW), .STEP_LOG2(STEP_LOG2), .STEP_CYC(STEP_CYC)) u_ramp (
        .clk(ref_clk), .rst_n(ref_rst_n), .en(state == ST_RAMP),
        .target(target_gain), .level(ramp_level), .done(ramp_done)
    );

    always_comb begin
        pwm_p_out   = pwm_p_in;
        pwm_m_out   = pwm_m_in;
        valid_out   = valid_in;
        proc_rst    = 1'b0;
        bus_hold    = 1'b0;
        ramp_active = 1'b0;
        gain        = '0;
        unique case (state)
            ST_RUN: gain = target_gain;
            ST_MUTE_HOLD: begin
                pwm_p_out = '0;
                pwm_m_out = '1;
                valid_out = '0;
                proc_rst  = 1'b1;
                bus_hold  = 1'b1;
            end
            ST_REINIT: begin
                pwm_p_out = '0;
                pwm_m_out = '1;
                valid_out = '0;
            end
            ST_PWM_RESTART: gain = '0;
            ST_RAMP: begin
                ramp_active = 1'b1;
                gain        = ramp_level;
            end
            default: begin
                pwm_p_out = '0;
                pwm_m_out = '1;
                valid_out = '0;
                proc_rst  = 1'b1;
                bus_hold  = 1'b1;
            end
        endcase
    end

    // R3: a fresh loss puts every leg at its mute level on the next cycle
    a_r3_mute_on_loss: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $rose(lost) |=> (pwm_p_out == '0 && pwm_m_out == '1 && valid_out == '0 && gain == '0));
    // R4: control bus and processing are held after a loss
    a_r4_hold_on_loss: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $rose(lost) |=> (proc_rst && bus_hold));
    // R7: gain never falls while ramping and never overshoots the target
    a_r7_ramp_monotonic: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (ramp_active && $past(ramp_active) && $stable(target_gain)) |-> gain >= $past(gain));
    a_r7_gain_bound: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        ramp_active |-> gain <= target_gain);
endmodule

// File: tb/clkloss_seq_test.sv
module clkloss_seq_test;
    localparam int PERIOD   = 10;
    localparam int CH       = 2;
    localparam int GW       = 8;
    localparam int LOSS     = 16;
    localparam int REINIT   = 40;
    localparam int RESTART  = 8;
    localparam int SLOG     = 2;
    localparam int SCYC     = 5;
    localparam int STEPS    = 1 << SLOG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mclk = 1'b0;
    logic          mclk_en = 1'b0;
    logic          rate_change = 1'b0;
    logic [GW-1:0] target_gain = 8'd200;
    logic [CH-1:0] p_in = '1, m_in = '0, v_in = '1;
    logic [CH-1:0] p_out, m_out, v_out;
    logic          proc_rst, bus_hold, ramp_active;
    logic [GW-1:0] gain;

    int checks = 0;
    int errors = 0;

    clkloss_seq #(.CH(CH), .GW(GW), .LOSS_CYC(LOSS), .REINIT_CYC(REINIT),
                  .RESTART_CYC(RESTART), .STEP_LOG2(SLOG), .STEP_CYC(SCYC)) uut (
        .ref_clk(clk), .ref_rst_n(rst_n), .mclk(mclk), .rate_change(rate_change),
        .target_gain(target_gain), .pwm_p_in(p_in), .pwm_m_in(m_in), .valid_in(v_in),
        .pwm_p_out(p_out), .pwm_m_out(m_out), .valid_out(v_out),
        .proc_rst(proc_rst), .bus_hold(bus_hold), .ramp_active(ramp_active), .gain(gain)
    );

    always #(PERIOD/2) clk = ~clk;
    always begin
        #7;
        if (mclk_en) mclk = ~mclk;
    end

    function automatic logic muted();
        return (p_out == '0) && (m_out == '1) && (v_out == '0);
    endfunction

    function automatic logic passing();
        return (p_out == p_in) && (m_out == m_in) && (v_out == v_in);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Follows one recovery from the safe state to RUN and checks each phase.
    task automatic follow_recovery(input int tgt);
        int n;
        int guard;
        guard = 0;
        while (!(muted() && !proc_rst) && guard < 2000) begin
            @(negedge clk); guard++;
        end
        n = 0;
        while (muted() && !proc_rst && n < 2000) begin
            check(gain == 0, "R3 gain zero in REINIT", gain, 0);
            n++; @(negedge clk);
        end
        check(n == REINIT, "R5 REINIT length", n, REINIT);
        n = 0;
        while (!muted() && !ramp_active && n < 2000) begin
            check(passing() && gain == 0, "R6 restart passes with zero gain", gain, 0);
            n++; @(negedge clk);
        end
        check(n == RESTART, "R6 PWM_RESTART length", n, RESTART);
        n = 0;
        while (ramp_active && n < 2000) begin
            int k;
            k = n / SCYC;
            if (k > STEPS) k = STEPS;
            check(gain == ((tgt * k) >> SLOG), "R7 ramp step value", gain, (tgt * k) >> SLOG);
            n++; @(negedge clk);
        end
        check(n == STEPS * SCYC + 1, "R7 ramp length", n, STEPS * SCYC + 1);
        check(gain == tgt, "R10 gain restored to target", gain, tgt);
        check(passing() && !proc_rst && !bus_hold && !ramp_active, "R1 RUN outputs", gain, tgt);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int tv [5];
        tv[0] = 0; tv[1] = 1; tv[2] = 255; tv[3] = 100; tv[4] = 37;
        tick(3);
        rst_n = 1'b1;
        tick(30);
        // R4: no clock after reset keeps the safe state
        check(muted() && proc_rst && bus_hold && gain == 0, "R4 safe state with no clock", gain, 0);
        check(muted(), "R3 mute levels", p_out, 0);
        mclk_en = 1'b1;
        follow_recovery(200);

        // R9 with R7 sweep: rate change from RUN for several targets
        foreach (tv[i]) begin
            target_gain = tv[i];
            tick(2);
            check(gain == tv[i], "R1 RUN gain tracks target", gain, tv[i]);
            rate_change = 1'b1;
            @(negedge clk);
            rate_change = 1'b0;
            check(muted() && proc_rst && bus_hold, "R9 rate change enters MUTE_HOLD", proc_rst, 1);
            follow_recovery(tv[i]);
        end

        // R2: short pause has no effect, longer pause mutes
        target_gain = 8'd180;
        tick(5);
        mclk_en = 1'b0;
        tick(10);
        check(passing() && gain == 180, "R2 short pause ignored", gain, 180);
        mclk_en = 1'b1;
        tick(10);
        check(passing() && gain == 180, "R2 after short pause still RUN", gain, 180);
        mclk_en = 1'b0;
        tick(LOSS + 6);
        check(muted() && bus_hold && proc_rst && gain == 0, "R2 loss after idle limit", gain, 0);
        tick(50);
        check(muted() && bus_hold, "R4 stays in MUTE_HOLD while clock missing", bus_hold, 1);
        mclk_en = 1'b1;
        follow_recovery(180);

        // R8: loss in the middle of the ramp
        rate_change = 1'b1;
        @(negedge clk);
        rate_change = 1'b0;
        begin
            int g;
            g = 0;
            while (!ramp_active && g < 2000) begin @(negedge clk); g++; end
        end
        tick(3);
        mclk_en = 1'b0;
        tick(LOSS + 6);
        check(muted() && bus_hold && !ramp_active && gain == 0, "R8 loss during RAMP mutes", gain, 0);
        mclk_en = 1'b1;
        follow_recovery(180);

        // R8: loss during REINIT
        rate_change = 1'b1;
        @(negedge clk);
        rate_change = 1'b0;
        tick(8);
        mclk_en = 1'b0;
        tick(LOSS + 6);
        check(muted() && bus_hold && proc_rst, "R8 loss during REINIT", proc_rst, 1);
        mclk_en = 1'b1;
        follow_recovery(180);

        // R9: rate change during RAMP restarts the sequence
        rate_change = 1'b1;
        @(negedge clk);
        rate_change = 1'b0;
        begin
            int g;
            g = 0;
            while (!ramp_active && g < 2000) begin @(negedge clk); g++; end
        end
        tick(4);
        rate_change = 1'b1;
        @(negedge clk);
        rate_change = 1'b0;
        check(muted() && proc_rst && !ramp_active, "R9 rate change during RAMP", proc_rst, 1);
        follow_recovery(180);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule